// File: doc/BRIEF.md
# Spread-Spectrum PLL Modulation Controller

This block sits beside a PLL and controls spread-spectrum clocking. A byte-wide control register holds a two-bit amplitude code. The register can be read at any time. A write lands only when the protection flag is low and the PLL is the selected clock source. Each write that lands also knocks down the lock and oscillator-good status flags, because the PLL has to settle again after its spread setting changes. External set pulses raise those flags again later.

The second part is a profile generator that runs on the reference clock. It emits a signed offset word, which is added to the nominal feedback divider value. The offset follows a symmetric triangle that repeats every 16 reference cycles, so the modulation rate is the reference frequency divided by 16. The peak of the triangle is 1%, 2% or 4% of the nominal divider, chosen by the amplitude code. Code 00 holds the offset at zero. A new code restarts the triangle from zero.

Top module: `ssc_mod_ctrl`

## Requirements
- R1: While reset is asserted (synchronous, active low), and on the first cycle after it, rd_data, lock_flag, oscok_flag and fm_offset are all zero.
- R2: The amplitude code sits in bits 5 and 4 of the control byte. An accepted write stores only those two bits. rd_data always shows them in the same positions, and every other bit reads as zero.
- R3: A write with prot_on high leaves the register, both status flags and the offset profile unchanged.
- R4: A write with pll_sel low leaves the register, both status flags and the offset profile unchanged.
- R5: An accepted write clears lock_flag and oscok_flag on the next edge. This clear wins over a set pulse that arrives in the same cycle.
- R6: With no accepted write, lock_set and oscok_set each raise their own flag on the next edge. With neither a set nor a clear, a flag holds its value.
- R7: While the stored code is 00 (off), fm_offset stays at zero.
- R8: The peak offset is div_nom/100 for code 01, div_nom/50 for code 10 and div_nom/25 for code 11, rounded toward zero. Over a full period the output reaches exactly +peak and -peak.
- R9: The profile has 16 phases, one per reference cycle. For phase p the step index k is p for p ≤ 4, 8−p for 4 < p ≤ 12, and p−16 for p > 12. The output is (peak·k)/4, rounded toward zero.
- R10: Call the edge on which the stored code changes edge t. On edge t+1 the offset becomes zero (phase 0). On edge t+2 it shows phase 1, and the triangle carries on from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write byte |
| rd_data | output | 8 | Register read byte |
| prot_on | input | 1 | Protection flag; high blocks writes |
| pll_sel | input | 1 | PLL selected as clock source; low blocks writes |
| lock_set | input | 1 | Set pulse from the lock detector |
| oscok_set | input | 1 | Set pulse from the oscillator monitor |
| lock_flag | output | 1 | Lock status bit |
| oscok_flag | output | 1 | Oscillator-good status bit |
| div_nom | input | DIV_W (10) | Nominal feedback divider value |
| fm_offset | output | DIV_W+1 (11) | Signed divider offset, two's complement |

## Verification
The bench builds the block with the default DIV_W of 10, so div_nom can reach 1023. Across the three amplitude codes that gives peaks from 0 up to 40. With this range the bench can try divider values whose peak rounds down to zero (a small div_nom with code 01), values where each ramp step truncates unevenly (a peak of 19 or 20), and the largest peak the width allows. A behavioural model runs beside the block and is compared on every clock. It therefore also covers code changes in the middle of a ramp and writes that the gating blocks.

// File: rtl/ssc_pkg.sv
// Package: shared types and constants for the spread-spectrum controller.
// Assumes one clock domain (the reference clock) for register and profile.
package ssc_pkg;

    typedef enum logic [1:0] {
        AMP_OFF  = 2'b00,
        AMP_PCT1 = 2'b01,
        AMP_PCT2 = 2'b10,
        AMP_PCT4 = 2'b11
    } amp_code_e;

    localparam int CODE_LSB    = 4;
    localparam int REG_W       = 8;
    localparam logic [REG_W-1:0] CODE_MASK = 8'h30;
    localparam int PHASE_W     = 4;   // 16 phases per modulation period
    localparam int NUM_FLAGS   = 2;   // index 0 = lock, index 1 = osc ok

endpackage

// File: rtl/ssc_ctrl_reg.sv
// Module: ssc_ctrl_reg
// Holds the amplitude-select control byte. A write is accepted only when
// protection is off and the PLL is the selected clock. Emits a one-cycle
// pulse for every accepted write so the status flags can be cleared.
// Assumes the write port runs on the same clock as the profile generator.
module ssc_ctrl_reg
    import ssc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             prot_on,
    input  logic             pll_sel,
    output logic [REG_W-1:0] rd_data,
    output amp_code_e        amp_code,
    output logic             wr_accept
);

    logic [REG_W-1:0] reg_q;

    // Write gating: both conditions must allow the write.
    always_comb wr_accept = wr_en && !prot_on && pll_sel;

    // Control byte storage; only the code field is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (wr_accept)
            reg_q <= wr_data & CODE_MASK;
    end

    // Read path and decoded code.
    always_comb begin
        rd_data  = reg_q;
        amp_code = amp_code_e'(reg_q[CODE_LSB +: 2]);
    end

    p_prot_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && prot_on) |=> $stable(reg_q));

    p_sel_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pll_sel) |=> $stable(reg_q));

    p_fixed_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> ((rd_data & ~CODE_MASK) == '0));

endmodule

// File: rtl/ssc_status_flags.sv
// Module: ssc_status_flags
// A bank of sticky status bits. Each bit is set by its own external pulse
// and all bits are cleared together by the clear pulse, which wins.
// Assumes set and clear pulses are synchronous to clk.
module ssc_status_flags
    import ssc_pkg::*;
#(
    parameter int N_FLAGS = NUM_FLAGS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [N_FLAGS-1:0] set,
    output logic [N_FLAGS-1:0] flags
);

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        logic flag_q;

        // One status bit: clear has priority over set, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (clr)
                flag_q <= 1'b0;
            else if (set[i])
                flag_q <= 1'b1;
        end

        assign flags[i] = flag_q;

        p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> !flag_q);

        p_set_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (set[i] && !clr) |=> flag_q);

        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!set[i] && !clr) |=> $stable(flag_q));
    end

endmodule

// File: rtl/ssc_triangle_gen.sv
// Module: ssc_triangle_gen
// Produces a signed divider offset that follows a 16-step triangle at the
// reference clock rate. The peak is a coded percentage of the nominal
// divider. The output is zero while modulation is off, and the phase restarts
// whenever the code changes.
// Assumes div_nom is quasi-static; a change simply rescales the next steps.
module ssc_triangle_gen
    import ssc_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  amp_code_e               amp_code,
    input  logic [DIV_W-1:0]        div_nom,
    output logic signed [DIV_W:0]   offset
);

    localparam int OFS_W  = DIV_W + 1;
    localparam int PROD_W = DIV_W + 3;

    amp_code_e           code_prev;
    logic [PHASE_W-1:0]  phase_q;
    logic [DIV_W-1:0]    peak;
    logic [2:0]          step_mag;
    logic                step_neg;
    logic [PROD_W-1:0]   scaled;
    logic signed [OFS_W-1:0] mag_s;
    logic signed [OFS_W-1:0] step_val;
    logic                restart;
    logic [PHASE_W:0]    ph_ext;

    // Peak amplitude from the code: 1%, 2% or 4% of the nominal divider.
    always_comb begin
        unique case (amp_code)
            AMP_PCT1: peak = div_nom / DIV_W'(100);
            AMP_PCT2: peak = div_nom / DIV_W'(50);
            AMP_PCT4: peak = div_nom / DIV_W'(25);
            default:  peak = '0;
        endcase
    end

    // Triangle step index for the current phase, as sign and magnitude.
    always_comb begin
        ph_ext = {1'b0, phase_q};
        if (ph_ext <= 5'd4) begin
            step_mag = 3'(ph_ext);
            step_neg = 1'b0;
        end else if (ph_ext <= 5'd8) begin
            step_mag = 3'(5'd8 - ph_ext);
            step_neg = 1'b0;
        end else if (ph_ext <= 5'd12) begin
            step_mag = 3'(ph_ext - 5'd8);
            step_neg = 1'b1;
        end else begin
            step_mag = 3'(5'd16 - ph_ext);
            step_neg = 1'b1;
        end
    end

    // Offset value: magnitude peak*|k|/4, then sign applied (rounds toward zero).
    always_comb begin
        scaled   = (PROD_W'(peak) * PROD_W'(step_mag)) >> 2;
        mag_s    = OFS_W'(scaled);
        step_val = step_neg ? -mag_s : mag_s;
    end

    // Restart when modulation is off or the code just changed.
    always_comb restart = (amp_code == AMP_OFF) || (amp_code != code_prev);

    // Phase counter, previous code and registered offset output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_prev <= AMP_OFF;
            phase_q   <= '0;
            offset    <= '0;
        end else begin
            code_prev <= amp_code;
            if (restart) begin
                phase_q <= PHASE_W'(1);
                offset  <= '0;
            end else begin
                phase_q <= phase_q + PHASE_W'(1);
                offset  <= step_val;
            end
        end
    end

    p_off_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_code == AMP_OFF) |=> (offset == '0));

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_code != code_prev) |=> (offset == '0 && phase_q == PHASE_W'(1)));

    p_upper_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && phase_q >= PHASE_W'(1) && phase_q <= PHASE_W'(7))
            |=> !offset[OFS_W-1]);

    p_lower_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && phase_q >= PHASE_W'(9)) |=> (offset <= 0));

endmodule

// File: rtl/ssc_mod_ctrl.sv
// Module: ssc_mod_ctrl (top)
// Spread-spectrum PLL modulation controller: protected amplitude register,
// lock / oscillator-good status bits cleared by accepted writes, and a
// triangle offset generator on the reference clock.
// Assumes a single reference clock and synchronous active-low reset.
module ssc_mod_ctrl
    import ssc_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_data,
    output logic [7:0]            rd_data,
    input  logic                  prot_on,
    input  logic                  pll_sel,
    input  logic                  lock_set,
    input  logic                  oscok_set,
    output logic                  lock_flag,
    output logic                  oscok_flag,
    input  logic [DIV_W-1:0]      div_nom,
    output logic signed [DIV_W:0] fm_offset
);

    amp_code_e              amp_code;
    logic                   wr_accept;
    logic [NUM_FLAGS-1:0]   flag_set;
    logic [NUM_FLAGS-1:0]   flag_val;

    // Gather status set pulses into the flag bank order.
    always_comb flag_set = {oscok_set, lock_set};

    ssc_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .prot_on   (prot_on),
        .pll_sel   (pll_sel),
        .rd_data   (rd_data),
        .amp_code  (amp_code),
        .wr_accept (wr_accept)
    );

    ssc_status_flags #(.N_FLAGS(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_accept),
        .set   (flag_set),
        .flags (flag_val)
    );

    ssc_triangle_gen #(.DIV_W(DIV_W)) u_tri (
        .clk      (clk),
        .rst_n    (rst_n),
        .amp_code (amp_code),
        .div_nom  (div_nom),
        .offset   (fm_offset)
    );

    // Status outputs from the flag bank.
    always_comb begin
        lock_flag  = flag_val[0];
        oscok_flag = flag_val[1];
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !lock_flag && !oscok_flag && fm_offset == '0));

endmodule

// File: tb/sim_ssc_mod_ctrl.sv
`timescale 1ns/1ps
// Bench for ssc_mod_ctrl: behavioural reference model compared every clock,
// plus directed checks for each requirement.
module sim_ssc_mod_ctrl;

    localparam int DIV_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic prot_on = 1'b0;
    logic pll_sel = 1'b1;
    logic lock_set = 1'b0;
    logic oscok_set = 1'b0;
    logic [DIV_W-1:0] div_nom = 10'd500;
    logic [7:0] rd_data;
    logic lock_flag, oscok_flag;
    logic signed [DIV_W:0] fm_offset;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ssc_mod_ctrl #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .prot_on(prot_on), .pll_sel(pll_sel),
        .lock_set(lock_set), .oscok_set(oscok_set), .lock_flag(lock_flag),
        .oscok_flag(oscok_flag), .div_nom(div_nom), .fm_offset(fm_offset)
    );

    // Reference model state
    int m_code = 0, m_prev = 0, m_ph = 0, m_ofs = 0;
    bit m_lock = 0, m_osc = 0;

    function automatic int peak_of(int code, int n);
        case (code)
            1: return n / 100;
            2: return n / 50;
            3: return n / 25;
            default: return 0;
        endcase
    endfunction

    function automatic int tri_k(int p);
        if (p <= 4) return p;
        if (p <= 12) return 8 - p;
        return p - 16;
    endfunction

    always @(posedge clk) begin
        int n_code, n_prev, n_ph, n_ofs;
        bit acc;
        if (!rst_n) begin
            m_code = 0; m_prev = 0; m_ph = 0; m_ofs = 0; m_lock = 0; m_osc = 0;
        end else begin
            acc = wr_en && !prot_on && pll_sel;
            n_prev = m_code;
            if (m_code == 0 || m_code != m_prev) begin
                n_ph = 1; n_ofs = 0;
            end else begin
                n_ofs = (peak_of(m_code, int'(div_nom)) * tri_k(m_ph)) / 4;
                n_ph = (m_ph + 1) % 16;
            end
            n_code = acc ? int'(wr_data[5:4]) : m_code;
            if (acc) begin m_lock = 0; m_osc = 0; end
            else begin
                if (lock_set) m_lock = 1;
                if (oscok_set) m_osc = 1;
            end
            m_code = n_code; m_prev = n_prev; m_ph = n_ph; m_ofs = n_ofs;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 rd_data vs model", int'(rd_data), m_code * 16);
            check("R5 lock_flag vs model", int'(lock_flag), int'(m_lock));
            check("R6 oscok_flag vs model", int'(oscok_flag), int'(m_osc));
            check("R9 fm_offset vs model", int'(fm_offset), m_ofs);
        end
    end

    task automatic do_write(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_flags();
        @(negedge clk);
        lock_set = 1'b1; oscok_set = 1'b1;
        @(negedge clk);
        lock_set = 1'b0; oscok_set = 1'b0;
    endtask

    task automatic span_check(string tag, int pk);
        int mx = -9999, mn = 9999;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (int'(fm_offset) > mx) mx = int'(fm_offset);
            if (int'(fm_offset) < mn) mn = int'(fm_offset);
        end
        check({tag, " max"}, mx, pk);
        check({tag, " min"}, mn, -pk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", int'(rd_data), 0);
        check("R1 flags in reset", int'({lock_flag, oscok_flag}), 0);
        check("R1 offset in reset", int'(fm_offset), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 offset after reset", int'(fm_offset), 0);

        // R6: set pulses raise flags
        set_flags();
        check("R6 lock set", int'(lock_flag), 1);
        check("R6 osc set", int'(oscok_flag), 1);
        repeat (2) @(negedge clk);
        check("R6 lock hold", int'(lock_flag), 1);

        // R2 and R5: write all ones with simultaneous set pulse
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hFF; lock_set = 1'b1; oscok_set = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; lock_set = 1'b0; oscok_set = 1'b0;
        check("R2 only code bits stored", int'(rd_data), 8'h30);
        check("R5 clear wins lock", int'(lock_flag), 0);
        check("R5 clear wins osc", int'(oscok_flag), 0);

        // R8: code 11, N=500 -> peak 20
        span_check("R8 code11 N500", 20);

        // R3: protected write ignored
        set_flags();
        prot_on = 1'b1;
        do_write(8'h10);
        check("R3 reg unchanged", int'(rd_data), 8'h30);
        check("R3 lock kept", int'(lock_flag), 1);
        prot_on = 1'b0;

        // R4: write without PLL selected ignored
        pll_sel = 1'b0;
        do_write(8'h00);
        check("R4 reg unchanged", int'(rd_data), 8'h30);
        check("R4 osc kept", int'(oscok_flag), 1);
        pll_sel = 1'b1;

        // R10: code change restarts phase; code 10, N=999 -> peak 19
        div_nom = 10'd999;
        do_write(8'h20);
        @(negedge clk);
        check("R10 zero after change", int'(fm_offset), 0);
        @(negedge clk);
        check("R10 phase one value", int'(fm_offset), 4);
        span_check("R8 code10 N999", 19);

        // R8: code 01, N=1023 -> 10; code 11, N=1023 -> 40
        div_nom = 10'd1023;
        do_write(8'h10);
        span_check("R8 code01 N1023", 10);
        do_write(8'h30);
        span_check("R8 code11 N1023", 40);

        // R8: small N rounds peak to zero
        div_nom = 10'd37;
        do_write(8'h10);
        span_check("R8 code01 N37", 0);

        // R7: code 00 keeps offset at zero
        div_nom = 10'd800;
        do_write(8'h30);
        repeat (6) @(negedge clk);
        do_write(8'h00);
        @(negedge clk);
        span_check("R7 off", 0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule